// File: doc/BRIEF.md
# Strap-Configured Synchronous SRAM Read Output Stage

This block forms the read side of a synchronous SRAM model: it turns a per-cycle command stream into a driven or floating data bus. Each clock edge captures one command: a read, a deselect, or an idle cycle that leaves the bus as it is. The read word comes from a memory array outside the block. That array registers its address on the edge that captures a read and holds its output until the next read.

Two mode straps are latched while reset is held. The latency strap picks one of two read paths. In flow-through mode the array word passes straight to the bus. In pipeline mode the word goes through a rising-edge output register. The deselect strap sets how far a deselect travels before the bus is released. With single-cycle deselect, the bus is released right after the deselect is captured. With dual-cycle deselect, the bus stays driven for one more full cycle. An asynchronous output enable floats the bus at once, whatever state the pipeline is in.

Top module: `sram_rd_pipe`

## Requirements
- R1: With `flow_thru_sel`=1 latched, a read captured at edge E sets `rd_vld` right after E, and `dout` shows `arr_data` combinationally.
- R2: With `flow_thru_sel`=0 latched, a read captured at edge E sets `rd_vld` after edge E+1. From then on `dout` shows the array word that was present between E and E+1.
- R3: With `dual_desel_sel`=0 latched, a deselect captured at edge E clears `rd_vld` right after E.
- R4: With `dual_desel_sel`=1 latched, a deselect captured at edge E leaves the bus state unchanged at E and clears `rd_vld` after edge E+1.
- R5: When two commands take effect on the same edge, the one issued later wins. A newer read beats an older deselect, and a newer deselect beats an older read.
- R6: `oe_n`=1 drops `dout_oe` at once, with no clock edge, and leaves `rd_vld` unchanged.
- R7: `dout_oe` is 1 only when `rd_vld`=1 and `oe_n`=0. When `dout_oe` is 0, `dout` is high-Z.
- R8: An idle cycle (`rd_req`=0 and `desel_req`=0) leaves `rd_vld` and the shown word unchanged.
- R9: The straps are sampled only on edges where `rst_n`=0. Changing them later has no effect.
- R10: A synchronous reset (`rst_n`=0 at an edge) clears `rd_vld` and `dout_oe` after that edge.
- R11: With both straps at 0, the block runs as single-cycle deselect with a pipelined read.
- R12: When `rd_req` and `desel_req` are both 1, the cycle is a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are latched while low |
| flow_thru_sel | input | 1 | Latency strap: 1 flow-through, 0 pipeline |
| dual_desel_sel | input | 1 | Deselect strap: 1 dual-cycle, 0 single-cycle |
| rd_req | input | 1 | Read command for this cycle |
| desel_req | input | 1 | Deselect command for this cycle (wins over rd_req) |
| oe_n | input | 1 | Asynchronous active-low output enable |
| arr_data | input | DATA_W | Word from the memory array, stable until the next read |
| dout | output | DATA_W | Tri-state read data bus |
| dout_oe | output | 1 | High while dout is driven |
| rd_vld | output | 1 | Pipelined read-valid flag |

## Verification
The in-line properties check on every edge the following:
- each mode's turn-on and turn-off edge relative to the command that caused it;
- hold across idle cycles;
- reset clearing the flag;
- the straps staying frozen once reset is released.

Only the bench scenarios can show the following:
- which word reaches the bus;
- that a later command overtakes an earlier one when both land on the same edge;
- that the output enable acts with no clock;
- that changing the straps after reset, or asserting read and deselect together, leaves the visible behaviour unchanged.

// File: rtl/sram_rd_pkg.sv
// Shared types for the SRAM read output stage.
// Assumes: one command per clock, decoded from two request lines.
package sram_rd_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_DESEL = 2'd2
    } cmd_e;

    typedef struct packed {
        logic flow_thru;   // 1: output register bypassed
        logic dual_desel;  // 1: deselect delayed one more edge
    } mode_t;
endpackage

// File: rtl/rd_mode_latch.sv
// Captures the two mode straps on every edge where reset is held and
// freezes them afterwards.
// Assumes: straps are settled before reset is released.
module rd_mode_latch
    import sram_rd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  flow_thru_sel,
    input  logic  dual_desel_sel,
    output mode_t mode_o
);
    // Purpose: sample the straps only while reset is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o.flow_thru  <= flow_thru_sel;
            mode_o.dual_desel <= dual_desel_sel;
        end
    end

    // R9
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_o));
endmodule

// File: rtl/rd_cmd_stage.sv
// Decodes the request lines into one command and keeps a copy of the
// command captured on the previous edge.
// Assumes: deselect takes priority when both requests are raised.
module rd_cmd_stage
    import sram_rd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic desel_req,
    output cmd_e cmd_now_o,
    output cmd_e cmd_reg_o
);
    // Purpose: priority decode of the current cycle's command.
    always_comb begin
        if (desel_req)   cmd_now_o = CMD_DESEL;
        else if (rd_req) cmd_now_o = CMD_READ;
        else             cmd_now_o = CMD_IDLE;
    end

    // Purpose: one-stage delay of the command, idle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_reg_o <= CMD_IDLE;
        else        cmd_reg_o <= cmd_now_o;
    end
endmodule

// File: rtl/rd_drive_ctl.sv
// Keeps the read-valid flag. A read or deselect acts either on the edge
// that captures it (age 0) or one edge later (age 1), as the straps
// select. On one edge an age-0 effect beats an age-1 effect.
// Assumes: mode is stable outside reset.
module rd_drive_ctl
    import sram_rd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t mode,
    input  cmd_e  cmd_now,
    input  cmd_e  cmd_reg,
    output logic  vld_o
);
    logic new_hit, new_val, old_hit, old_val, vld_nx;

    // Purpose: effect of the command captured on this edge.
    always_comb begin
        new_hit = 1'b0;
        new_val = 1'b0;
        if (mode.flow_thru && cmd_now == CMD_READ) begin
            new_hit = 1'b1;
            new_val = 1'b1;
        end else if (!mode.dual_desel && cmd_now == CMD_DESEL) begin
            new_hit = 1'b1;
            new_val = 1'b0;
        end
    end

    // Purpose: effect of the command captured on the previous edge.
    always_comb begin
        old_hit = 1'b0;
        old_val = 1'b0;
        if (!mode.flow_thru && cmd_reg == CMD_READ) begin
            old_hit = 1'b1;
            old_val = 1'b1;
        end else if (mode.dual_desel && cmd_reg == CMD_DESEL) begin
            old_hit = 1'b1;
            old_val = 1'b0;
        end
    end

    // Purpose: newer command wins, otherwise hold.
    always_comb begin
        if (new_hit)      vld_nx = new_val;
        else if (old_hit) vld_nx = old_val;
        else              vld_nx = vld_o;
    end

    // Purpose: valid flag register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= vld_nx;
    end

    // R1
    ft_read_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.flow_thru && cmd_now == CMD_READ) |=> vld_o);
    // R2
    pl_read_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode.flow_thru && cmd_reg == CMD_READ &&
         !(!mode.dual_desel && cmd_now == CMD_DESEL)) |=> vld_o);
    // R3
    scd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode.dual_desel && cmd_now == CMD_DESEL) |=> !vld_o);
    // R4
    dcd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.dual_desel && cmd_reg == CMD_DESEL &&
         !(mode.flow_thru && cmd_now == CMD_READ)) |=> !vld_o);
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_now == CMD_IDLE && cmd_reg == CMD_IDLE) |=> (vld_o == $past(vld_o)));
    // R10
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !vld_o);
endmodule

// File: rtl/rd_data_path.sv
// Read word path: an output register loaded one edge after a read is
// captured, and a mux that bypasses it in flow-through mode.
// Assumes: arr_data is valid from the edge that captures a read until
// the next captured read.
module rd_data_path
    import sram_rd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow_thru,
    input  cmd_e              cmd_reg,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] q_reg;

    // Purpose: output register, loaded when the delayed command is a read.
    always_ff @(posedge clk) begin
        if (!rst_n)                   q_reg <= '0;
        else if (cmd_reg == CMD_READ) q_reg <= arr_data;
    end

    // Purpose: select the bypass or the registered word.
    always_comb begin
        data_o = flow_thru ? arr_data : q_reg;
    end
endmodule

// File: rtl/sram_rd_pipe.sv
// Top of the SRAM read output stage: strap latch, command stage, valid
// control, data path, and an asynchronous tri-state driver.
// Assumes: the array is outside the block and follows the timing
// stated in rd_data_path.
module sram_rd_pipe
    import sram_rd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow_thru_sel,
    input  logic              dual_desel_sel,
    input  logic              rd_req,
    input  logic              desel_req,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              rd_vld
);
    mode_t             mode;
    cmd_e              cmd_now, cmd_reg;
    logic [DATA_W-1:0] word;

    rd_mode_latch u_mode (
        .clk(clk), .rst_n(rst_n), .flow_thru_sel(flow_thru_sel),
        .dual_desel_sel(dual_desel_sel), .mode_o(mode)
    );

    rd_cmd_stage u_cmd (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .desel_req(desel_req),
        .cmd_now_o(cmd_now), .cmd_reg_o(cmd_reg)
    );

    rd_drive_ctl u_drv (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cmd_now(cmd_now),
        .cmd_reg(cmd_reg), .vld_o(rd_vld)
    );

    rd_data_path #(.DATA_W(DATA_W)) u_data (
        .clk(clk), .rst_n(rst_n), .flow_thru(mode.flow_thru),
        .cmd_reg(cmd_reg), .arr_data(arr_data), .data_o(word)
    );

    // Purpose: drive the bus only while valid and enabled; no clock involved.
    assign dout_oe = rd_vld & ~oe_n;
    assign dout    = dout_oe ? word : 'z;
endmodule

// File: tb/sram_rd_pipe_bench.sv
module sram_rd_pipe_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    typedef struct packed {
        logic [1:0] mode;    // {flow_thru, dual_desel}
        logic       rd;
        logic       ds;
        logic       exp_v;
        logic [7:0] exp_idx; // read whose word is on the bus
        logic [7:0] req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        // pipeline, single deselect (both straps 0): R11
        '{2'b00,1'b1,1'b0,1'b0,8'd0, 8'd2},  // R2 not yet
        '{2'b00,1'b0,1'b0,1'b1,8'd0, 8'd2},  // R2 on
        '{2'b00,1'b1,1'b0,1'b1,8'd0, 8'd8},  // R8
        '{2'b00,1'b0,1'b1,1'b0,8'd0, 8'd5},  // R5 deselect beats older read
        '{2'b00,1'b1,1'b0,1'b0,8'd0, 8'd3},  // R3
        '{2'b00,1'b1,1'b0,1'b1,8'd4, 8'd2},  // R2
        '{2'b00,1'b0,1'b0,1'b1,8'd5, 8'd2},  // R2
        '{2'b00,1'b0,1'b0,1'b1,8'd5, 8'd8},  // R8
        '{2'b00,1'b0,1'b1,1'b0,8'd0, 8'd3},  // R3
        // pipeline, dual deselect
        '{2'b01,1'b1,1'b0,1'b0,8'd0, 8'd2},
        '{2'b01,1'b0,1'b1,1'b1,8'd9, 8'd4},  // R4 still driven
        '{2'b01,1'b0,1'b0,1'b0,8'd0, 8'd4},  // R4 off
        '{2'b01,1'b1,1'b0,1'b0,8'd0, 8'd4},
        '{2'b01,1'b1,1'b0,1'b1,8'd12,8'd2},
        '{2'b01,1'b0,1'b1,1'b1,8'd13,8'd4},
        '{2'b01,1'b1,1'b0,1'b0,8'd0, 8'd4},
        '{2'b01,1'b0,1'b0,1'b1,8'd15,8'd2},
        // flow-through, single deselect
        '{2'b10,1'b1,1'b0,1'b1,8'd17,8'd1},  // R1
        '{2'b10,1'b0,1'b0,1'b1,8'd17,8'd8},  // R8
        '{2'b10,1'b1,1'b0,1'b1,8'd19,8'd1},
        '{2'b10,1'b0,1'b1,1'b0,8'd0, 8'd3},
        '{2'b10,1'b0,1'b0,1'b0,8'd0, 8'd3},
        '{2'b10,1'b1,1'b0,1'b1,8'd22,8'd1},
        // flow-through, dual deselect
        '{2'b11,1'b1,1'b0,1'b1,8'd23,8'd1},
        '{2'b11,1'b0,1'b1,1'b1,8'd23,8'd4},
        '{2'b11,1'b0,1'b0,1'b0,8'd0, 8'd4},
        '{2'b11,1'b1,1'b0,1'b1,8'd26,8'd1},
        '{2'b11,1'b0,1'b1,1'b1,8'd26,8'd4},
        '{2'b11,1'b1,1'b0,1'b1,8'd28,8'd5},  // R5 newer read beats deselect
        '{2'b11,1'b0,1'b1,1'b1,8'd28,8'd4},
        '{2'b11,1'b0,1'b1,1'b0,8'd0, 8'd4},
        '{2'b11,1'b0,1'b0,1'b0,8'd0, 8'd4}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic ft_s = 1'b0, dd_s = 1'b0, rd = 1'b0, ds = 1'b0, oe_n = 1'b0;
    logic [7:0]   addr = 8'd0;
    logic [W-1:0] arr_q = '0;
    logic [W-1:0] dout;
    logic dout_oe, rd_vld;
    int total = 0, bad = 0;
    bit done = 1'b0;

    sram_rd_pipe #(.DATA_W(W)) u_sram_rd_pipe (
        .clk(clk), .rst_n(rst_n), .flow_thru_sel(ft_s), .dual_desel_sel(dd_s),
        .rd_req(rd), .desel_req(ds), .oe_n(oe_n), .arr_data(arr_q),
        .dout(dout), .dout_oe(dout_oe), .rd_vld(rd_vld)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // array harness: registers the address of each accepted read
    always_ff @(posedge clk) begin
        if (rd && !ds) arr_q <= 16'h5A00 | {8'd0, addr};
    end

    function automatic logic [W-1:0] word_of(input logic [7:0] a);
        return 16'h5A00 | {8'd0, a};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        rst_n = 1'b0; rd = 1'b0; ds = 1'b0;
        ft_s = m[1]; dd_s = m[0];
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input logic r, input logic d, input logic [7:0] a);
        rd = r; ds = d; addr = a;
        @(posedge clk); @(negedge clk);
        rd = 1'b0; ds = 1'b0;
    endtask

    initial begin
        logic [1:0] cur;
        cur = 2'b00;
        for (int i = 0; i < NV; i++) begin
            if (i == 0 || VEC[i].mode != cur) begin
                cur = VEC[i].mode;
                do_reset(cur);
                // R10
                chk(rd_vld == 1'b0, "R10 vld after reset", rd_vld, 0);
                chk(dout_oe == 1'b0, "R10 oe after reset", dout_oe, 0);
            end
            step(VEC[i].rd, VEC[i].ds, 8'(i));
            chk(rd_vld == VEC[i].exp_v, $sformatf("R%0d vld vec %0d", VEC[i].req, i),
                rd_vld, VEC[i].exp_v);
            // R7
            chk(dout_oe == VEC[i].exp_v, $sformatf("R7 oe vec %0d", i), dout_oe, VEC[i].exp_v);
            if (VEC[i].exp_v)
                chk(dout == word_of(VEC[i].exp_idx), $sformatf("R%0d data vec %0d", VEC[i].req, i),
                    dout, word_of(VEC[i].exp_idx));
        end

        // R11: both straps 0 gives a two-edge read
        do_reset(2'b00);
        step(1'b1, 1'b0, 8'd44);
        chk(rd_vld == 1'b0, "R11 vld first edge", rd_vld, 0);
        step(1'b0, 1'b0, 8'd0);
        chk(rd_vld == 1'b1, "R11 vld second edge", rd_vld, 1);
        chk(dout == word_of(8'd44), "R11 data", dout, word_of(8'd44));

        // R6 / R7: asynchronous output enable
        oe_n = 1'b1; #1;
        chk(dout_oe == 1'b0, "R6 oe drops at once", dout_oe, 0);
        chk(rd_vld == 1'b1, "R6 vld kept", rd_vld, 1);
        oe_n = 1'b0; #1;
        chk(dout_oe == 1'b1, "R7 oe back", dout_oe, 1);
        chk(dout == word_of(8'd44), "R7 data back", dout, word_of(8'd44));

        // R12: read and deselect together act as deselect
        step(1'b1, 1'b1, 8'd41);
        chk(rd_vld == 1'b0, "R12 first edge", rd_vld, 0);
        step(1'b0, 1'b0, 8'd0);
        chk(rd_vld == 1'b0, "R12 second edge", rd_vld, 0);

        // R9: straps changed after reset are ignored
        do_reset(2'b10);
        ft_s = 1'b0; dd_s = 1'b1;
        step(1'b1, 1'b0, 8'd42);
        chk(rd_vld == 1'b1, "R9 still flow-through", rd_vld, 1);
        chk(dout == word_of(8'd42), "R9 data", dout, word_of(8'd42));
        step(1'b0, 1'b1, 8'd0);
        chk(rd_vld == 1'b0, "R9 still single deselect", rd_vld, 0);

        // R10: reset in mid-operation
        step(1'b1, 1'b0, 8'd43);
        chk(rd_vld == 1'b1, "R10 before reset", rd_vld, 1);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(rd_vld == 1'b0, "R10 vld cleared", rd_vld, 0);
        chk(dout_oe == 1'b0, "R10 oe cleared", dout_oe, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule